// File: doc/BRIEF.md
# Dual-Issue Pairing Logic

This block decides, every cycle, how many of the two oldest decoded instructions can start execution in a machine with two integer pipelines running side by side. Each candidate instruction comes with two source register numbers, a destination register number, a destination write flag and an opaque payload. The older candidate always goes to pipe 0. The younger one is sent to pipe 1 in the same cycle only if it is fully independent of the older one. The two pipelines have no path for passing results to each other, so a dependent pair cannot share a cycle. In that case pipe 1 receives nothing and the younger instruction waits to become the older one in the next cycle.

The instruction queue sits in front of the block. The queue presents its head entry on the `a_*` inputs and the entry behind it on the `b_*` inputs. It pops `take_cnt` entries at the next clock edge. The issue register inside the block holds the payloads handed to each pipe, together with their valid flags. A downstream stall freezes that register and makes `take_cnt` zero. When every pair is independent, two instructions complete per cycle, which gives an average of half a cycle per instruction.

Top module: `dual_issue_pick`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first issue, `p0_valid` and `p1_valid` are 0 and `p0_data` and `p1_data` are 0.
- R2: With both candidates valid and independent, and no stall, `take_cnt` is 2. After the next rising edge, `p0_data` equals the older payload and `p1_data` equals the younger payload, and both valid flags are 1.
- R3: If the older candidate writes a nonzero register (`a_we`=1) and either source of the younger candidate names that register, `take_cnt` is 1. After the edge, only pipe 0 is valid, and it carries the older payload.
- R4: If both candidates write (`a_we`=`b_we`=1) the same nonzero register, they issue singly as in R3. If the younger one does not write, an equal destination number alone does not split the pair.
- R5: Register number 0 never creates a dependence, whether it appears as the older destination or in any field of the younger candidate.
- R6: An older candidate with `a_we`=0 creates no dependence, even when its destination number matches a younger source.
- R7: With only the older candidate valid, `take_cnt` is 1, it issues to pipe 0, and pipe 1 is not valid.
- R8: With the older candidate not valid, `take_cnt` is 0 and neither pipe is valid after the edge, even if the younger slot claims to be valid.
- R9: While `stall_i` is 1, `take_cnt` is 0 and all four pipe outputs keep their values across the edge.
- R10: Over any instruction stream, pipe 0 always carries the oldest unissued instruction. Pipe 1 is valid only together with pipe 0 and carries the next instruction in order. A dependent pair is never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| stall_i | input | 1 | Downstream cannot accept; hold issue register |
| a_valid | input | 1 | Older candidate present |
| a_rs1 | input | RW | Older first source register |
| a_rs2 | input | RW | Older second source register |
| a_rd | input | RW | Older destination register |
| a_we | input | 1 | Older writes its destination |
| a_data | input | DW | Older payload |
| b_valid | input | 1 | Younger candidate present |
| b_rs1 | input | RW | Younger first source register |
| b_rs2 | input | RW | Younger second source register |
| b_rd | input | RW | Younger destination register |
| b_we | input | 1 | Younger writes its destination |
| b_data | input | DW | Younger payload |
| take_cnt | output | 2 | Entries the queue pops at the next edge (0, 1 or 2) |
| p0_valid | output | 1 | Pipe 0 holds an instruction |
| p0_data | output | DW | Payload for pipe 0 |
| p1_valid | output | 1 | Pipe 1 holds an instruction |
| p1_data | output | DW | Payload for pipe 1 |

## Verification
Directed pairs separate the two kinds of read-after-write collision (through the first source and through the second) from the write-after-write collision. They also show that register 0, a non-writing older instruction and a non-writing younger instruction with a matching destination each leave the pair intact. Single-candidate patterns, patterns with only the younger slot valid, and stalled patterns show whether the pop count and the issue register follow the queue contents or ignore them. A long stream of random instructions, drawn from only four register numbers so that collisions are frequent, is consumed through a model queue. This stream shows whether program order, pipe assignment and the no-dependent-pair rule hold under random stalls.

// File: rtl/dual_issue_pick.sv
module dual_issue_pick #(
  parameter int RW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall_i,
  input  logic          a_valid,
  input  logic [RW-1:0] a_rs1,
  input  logic [RW-1:0] a_rs2,
  input  logic [RW-1:0] a_rd,
  input  logic          a_we,
  input  logic [DW-1:0] a_data,
  input  logic          b_valid,
  input  logic [RW-1:0] b_rs1,
  input  logic [RW-1:0] b_rs2,
  input  logic [RW-1:0] b_rd,
  input  logic          b_we,
  input  logic [DW-1:0] b_data,
  output logic [1:0]    take_cnt,
  output logic          p0_valid,
  output logic [DW-1:0] p0_data,
  output logic          p1_valid,
  output logic [DW-1:0] p1_data
);

  logic a_writes, raw_hit, waw_hit, pair_ok;

  assign a_writes = a_we && (a_rd != '0);
  assign raw_hit  = a_writes && ((b_rs1 == a_rd) || (b_rs2 == a_rd));
  assign waw_hit  = a_writes && b_we && (b_rd == a_rd);
  assign pair_ok  = a_valid && b_valid && !raw_hit && !waw_hit;

  assign take_cnt = (stall_i || !a_valid) ? 2'd0 : (pair_ok ? 2'd2 : 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p0_valid <= 1'b0;
      p0_data  <= '0;
      p1_valid <= 1'b0;
      p1_data  <= '0;
    end else if (!stall_i) begin
      p0_valid <= a_valid;
      p0_data  <= a_data;
      p1_valid <= pair_ok;
      p1_data  <= b_data;
    end
  end

endmodule

// File: rtl/dual_issue_pick_chk.sv
module dual_issue_pick_chk #(
  parameter int RW = 5,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall_i,
  input logic          a_valid,
  input logic [RW-1:0] a_rs1,
  input logic [RW-1:0] a_rs2,
  input logic [RW-1:0] a_rd,
  input logic          a_we,
  input logic          b_valid,
  input logic [RW-1:0] b_rs1,
  input logic [RW-1:0] b_rs2,
  input logic [RW-1:0] b_rd,
  input logic          b_we,
  input logic [1:0]    take_cnt,
  input logic          p0_valid,
  input logic [DW-1:0] p0_data,
  input logic          p1_valid,
  input logic [DW-1:0] p1_data
);

  AST_RAW_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && a_valid && b_valid && a_we && a_rd != '0 && (b_rs1 == a_rd || b_rs2 == a_rd))
      |-> take_cnt == 2'd1); // R3

  AST_WAW_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && a_valid && b_valid && a_we && b_we && a_rd != '0 && b_rd == a_rd)
      |-> take_cnt == 2'd1); // R4

  AST_NO_OLDER: assert property (@(posedge clk) disable iff (!rst_n)
    !a_valid |-> take_cnt == 2'd0); // R8

  AST_STALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |-> take_cnt == 2'd0); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> $stable(p0_valid) && $stable(p1_valid) && $stable(p0_data) && $stable(p1_data)); // R9

  AST_P1_WITH_P0: assert property (@(posedge clk) disable iff (!rst_n)
    p1_valid |-> p0_valid); // R10

  AST_PAIR_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
    (take_cnt == 2'd2) |=> p0_valid && p1_valid); // R2

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    take_cnt != 2'd3); // R10

endmodule

bind dual_issue_pick dual_issue_pick_chk #(.RW(RW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall_i(stall_i),
  .a_valid(a_valid), .a_rs1(a_rs1), .a_rs2(a_rs2), .a_rd(a_rd), .a_we(a_we),
  .b_valid(b_valid), .b_rs1(b_rs1), .b_rs2(b_rs2), .b_rd(b_rd), .b_we(b_we),
  .take_cnt(take_cnt), .p0_valid(p0_valid), .p0_data(p0_data),
  .p1_valid(p1_valid), .p1_data(p1_data)
);

// File: tb/tb_dual_issue_pick.sv
module tb_dual_issue_pick;
  localparam int CLK_P = 10;
  localparam int RW = 5;
  localparam int DW = 16;
  localparam int NSTREAM = 400;

  typedef struct packed {
    logic          v;
    logic [RW-1:0] s1;
    logic [RW-1:0] s2;
    logic [RW-1:0] d;
    logic          w;
    logic [DW-1:0] dat;
  } ins_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stall_i = 1'b0;
  ins_t ia = '0, ib = '0;
  logic [1:0] take_cnt;
  logic p0_valid, p1_valid;
  logic [DW-1:0] p0_data, p1_data;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  dual_issue_pick #(.RW(RW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i),
    .a_valid(ia.v), .a_rs1(ia.s1), .a_rs2(ia.s2), .a_rd(ia.d), .a_we(ia.w), .a_data(ia.dat),
    .b_valid(ib.v), .b_rs1(ib.s1), .b_rs2(ib.s2), .b_rd(ib.d), .b_we(ib.w), .b_data(ib.dat),
    .take_cnt(take_cnt), .p0_valid(p0_valid), .p0_data(p0_data),
    .p1_valid(p1_valid), .p1_data(p1_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit depends(input ins_t o, input ins_t y);
    bit wr = o.w && (o.d != 0);
    return wr && ((y.s1 == o.d) || (y.s2 == o.d) || (y.w && y.d == o.d));
  endfunction

  function automatic ins_t mk(input bit v, input int s1, input int s2, input int d, input bit w, input int dat);
    ins_t t;
    t.v = v; t.s1 = RW'(s1); t.s2 = RW'(s2); t.d = RW'(d); t.w = w; t.dat = DW'(dat);
    return t;
  endfunction

  task automatic step(input ins_t a, input ins_t b, input bit st, input int et,
                      input bit e0v, input int e0d, input bit e1v, input int e1d, input string req);
    @(negedge clk);
    ia = a; ib = b; stall_i = st;
    #1;
    chk(take_cnt == 2'(et), {req, " take_cnt"}, 32'(take_cnt), 32'(et));
    @(posedge clk);
    #1;
    chk(p0_valid == e0v, {req, " p0_valid"}, 32'(p0_valid), 32'(e0v));
    chk(p1_valid == e1v, {req, " p1_valid"}, 32'(p1_valid), 32'(e1v));
    if (e0v) chk(p0_data == DW'(e0d), {req, " p0_data"}, 32'(p0_data), 32'(e0d));
    if (e1v) chk(p1_data == DW'(e1d), {req, " p1_data"}, 32'(p1_data), 32'(e1d));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!p0_valid && !p1_valid, "R1 valids in reset", {p0_valid, p1_valid}, 0);
    chk(p0_data == 0 && p1_data == 0, "R1 data in reset", {p0_data, p1_data}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!p0_valid && !p1_valid && p0_data == 0, "R1 after release", {p0_valid, p1_valid}, 0);
  endtask

  task automatic t_independent;
    step(mk(1,1,2,3,1,'h11), mk(1,4,5,6,1,'h12), 0, 2, 1,'h11, 1,'h12, "R2 independent");
  endtask

  task automatic t_raw;
    step(mk(1,1,2,3,1,'h21), mk(1,3,5,6,1,'h22), 0, 1, 1,'h21, 0,0, "R3 rs1 collision");
    step(mk(1,1,2,7,1,'h23), mk(1,4,7,6,0,'h24), 0, 1, 1,'h23, 0,0, "R3 rs2 collision");
  endtask

  task automatic t_waw;
    step(mk(1,1,2,9,1,'h31), mk(1,4,5,9,1,'h32), 0, 1, 1,'h31, 0,0, "R4 same dest");
    step(mk(1,1,2,9,1,'h33), mk(1,4,5,9,0,'h34), 0, 2, 1,'h33, 1,'h34, "R4 younger no write");
  endtask

  task automatic t_zero;
    step(mk(1,1,2,0,1,'h41), mk(1,0,0,0,1,'h42), 0, 2, 1,'h41, 1,'h42, "R5 register zero");
  endtask

  task automatic t_nowrite;
    step(mk(1,1,2,8,0,'h51), mk(1,8,8,8,1,'h52), 0, 2, 1,'h51, 1,'h52, "R6 older no write");
  endtask

  task automatic t_single;
    step(mk(1,1,2,3,1,'h61), mk(0,4,5,6,1,'h62), 0, 1, 1,'h61, 0,0, "R7 older alone");
  endtask

  task automatic t_empty;
    step(mk(0,1,2,3,1,'h71), mk(1,4,5,6,1,'h72), 0, 0, 0,0, 0,0, "R8 younger alone");
    step(mk(0,1,2,3,1,'h73), mk(0,4,5,6,1,'h74), 0, 0, 0,0, 0,0, "R8 nothing valid");
  endtask

  task automatic t_stall;
    step(mk(1,1,2,3,1,'h81), mk(1,4,5,6,1,'h82), 0, 2, 1,'h81, 1,'h82, "R9 setup");
    step(mk(1,1,2,3,1,'h83), mk(1,4,5,6,1,'h84), 1, 0, 1,'h81, 1,'h82, "R9 stall holds pair");
    step(mk(1,1,2,3,1,'h85), mk(0,4,5,6,1,'h86), 1, 0, 1,'h81, 1,'h82, "R9 stall holds again");
    step(mk(1,1,2,3,1,'h87), mk(1,3,5,6,1,'h88), 0, 1, 1,'h87, 0,0, "R9 resume");
  endtask

  task automatic t_stream;
    ins_t q[NSTREAM];
    int head = 0;
    int errs = 0;
    for (int i = 0; i < NSTREAM; i++)
      q[i] = mk(1, $urandom_range(0,3), $urandom_range(0,3), $urandom_range(0,3),
                $urandom_range(0,1), 'h100 + i);
    while (head < NSTREAM) begin
      ins_t a, b;
      bit st, dep;
      int exp_take;
      bit e0v, e1v;
      logic [1:0] got;
      a = q[head];
      b = (head + 1 < NSTREAM) ? q[head + 1] : '0;
      st = ($urandom_range(0,5) == 0);
      dep = b.v && depends(a, b);
      exp_take = st ? 0 : ((b.v && !dep) ? 2 : 1);
      @(negedge clk);
      ia = a; ib = b; stall_i = st;
      #1;
      got = take_cnt;
      if (got != 2'(exp_take)) begin
        errs++;
        chk(0, "R10 stream take_cnt", 32'(got), 32'(exp_take));
      end
      if (got == 2 && dep) begin
        errs++;
        chk(0, "R10 dependent pair issued", 32'(got), 1);
      end
      @(posedge clk);
      #1;
      if (!st) begin
        e0v = 1'b1;
        e1v = (exp_take == 2);
        if (p0_valid != e0v || p0_data != a.dat) begin
          errs++;
          chk(0, "R10 pipe0 order", 32'(p0_data), 32'(a.dat));
        end
        if (p1_valid != e1v || (e1v && p1_data != b.dat)) begin
          errs++;
          chk(0, "R10 pipe1 order", {p1_valid, 15'd0, p1_data}, {e1v, 15'd0, b.dat});
        end
        head += exp_take;
      end
    end
    chk(errs == 0, "R10 stream summary", 32'(errs), 0);
  endtask

  initial begin
    t_reset;
    t_independent;
    t_raw;
    t_waw;
    t_zero;
    t_nowrite;
    t_single;
    t_empty;
    t_stall;
    t_stream;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule